// File: doc/BRIEF.md
# Watermark-Gated DMA Write FIFO

This block is the elastic buffer of one DMA write channel. A memory-side producer pushes data words into a small FIFO. The bus side receives those words in fixed-length bursts. A burst may begin only when two conditions both hold: the fill level is strictly above a software-set watermark, and a bus-master enable bit is set. A non-empty FIFO is not enough to begin a burst.

When both conditions hold, the block raises a burst request. After the request is granted, the block sends exactly `BURST_LEN` words in arrival order over a valid/ready handshake. It then returns to idle and evaluates the start condition again. A small register port lets software read and write the enable bit and the watermark.

Top module: `dma_wm_fifo`

## Requirements
- R1: After reset, the enable bit reads 0, the watermark reads 0, and `full`, `burst_req` and `out_valid` are all 0.
- R2: A register write with `reg_addr`=0 sets the enable bit from bit 0 of `reg_wdata`. A register write with `reg_addr`=1 sets the watermark (width `$clog2(DEPTH+1)`, range 0 to DEPTH). `reg_rdata` returns the selected register, with the enable bit in bit 0 and the upper bits 0.
- R3: `burst_req` is never 1 while the enable bit is 0.
- R4: In idle, `burst_req` is 1 exactly when the enable bit is 1 and the fill level is strictly greater than the watermark. With a watermark of 0, a single queued word is enough. With a watermark equal to DEPTH, a request is never raised.
- R5: When `burst_req` and `burst_gnt` are both 1 at a clock edge, a burst starts. The burst moves exactly `BURST_LEN` words in FIFO order. `out_valid` is 1 only inside a burst and only while the FIFO holds data. The burst keeps draining after the level falls to or below the watermark, and it waits while the FIFO is empty. `burst_req` stays 0 during a burst.
- R6: If the enable bit is cleared during a burst, that burst still completes. No new request is raised until the enable bit is set again.
- R7: `full` is 1 when DEPTH words are queued. A push while `full` is 1 is dropped and leaves the stored words and their order unchanged.
- R8: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_data` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 = enable, 1 = watermark |
| reg_wdata | input | $clog2(DEPTH+1) | Register write data |
| reg_rdata | output | $clog2(DEPTH+1) | Read data for the selected register |
| push_valid | input | 1 | Producer push strobe |
| push_data | input | DATA_W | Producer data word |
| full | output | 1 | FIFO holds DEPTH words |
| burst_req | output | 1 | Request to start a bus write burst |
| burst_gnt | input | 1 | Grant for the pending request |
| out_valid | output | 1 | Bus-side word available |
| out_data | output | DATA_W | Bus-side data word |
| out_ready | input | 1 | Bus side accepts the word |

## Verification
The bench builds the block with DEPTH=8, BURST_LEN=4 and DATA_W=16. With a depth of 8, the bench can reach the full condition and a watermark equal to the depth within a few pushes. A burst of 4 words is shorter than the depth, so several cases fit in one run:
- the level falling to or below the watermark while a burst is still active,
- an empty FIFO in the middle of a burst,
- two bursts draining one full FIFO.

// File: rtl/dwm_pkg.sv
package dwm_pkg;
   typedef enum logic {
      ST_IDLE  = 1'b0,
      ST_BURST = 1'b1
   } burst_st_e;

   localparam logic REG_SEL_EN = 1'b0;
   localparam logic REG_SEL_WM = 1'b1;
endpackage

// File: rtl/dwm_store.sv
module dwm_store #(
   parameter int DATA_W = 32,
   parameter int DEPTH  = 16,
   localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CW    = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_en,
   output logic [DATA_W-1:0] rd_data,
   output logic [CW-1:0]     level,
   output logic              full,
   output logic              empty
);
   logic [DATA_W-1:0] mem_q [DEPTH];
   logic [AW-1:0]     wr_ptr_q, rd_ptr_q;
   logic              wr_ok, rd_ok;

   assign full  = (level == CW'(DEPTH));
   assign empty = (level == '0);
   assign wr_ok = wr_en && !full;
   assign rd_ok = rd_en && !empty;
   assign rd_data = mem_q[rd_ptr_q];

   always_ff @(posedge clk) begin
      if (wr_ok) mem_q[wr_ptr_q] <= wr_data;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr_q <= '0;
         rd_ptr_q <= '0;
         level    <= '0;
      end else begin
         if (wr_ok) wr_ptr_q <= wr_ptr_q + AW'(1);
         if (rd_ok) rd_ptr_q <= rd_ptr_q + AW'(1);
         case ({wr_ok, rd_ok})
            2'b10:   level <= level + CW'(1);
            2'b01:   level <= level - CW'(1);
            default: level <= level;
         endcase
      end
   end
endmodule

// File: rtl/dwm_regs.sv
module dwm_regs #(
   parameter int DEPTH = 16,
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic          addr,
   input  logic [CW-1:0] wdata,
   output logic [CW-1:0] rdata,
   output logic          bus_en,
   output logic [CW-1:0] wmark
);
   import dwm_pkg::*;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bus_en <= 1'b0;
         wmark  <= '0;
      end else if (we) begin
         if (addr == REG_SEL_EN) bus_en <= wdata[0];
         else                    wmark  <= wdata;
      end
   end

   generate
      if (CW > 1) begin : g_wide
         assign rdata = (addr == REG_SEL_EN) ? {{(CW-1){1'b0}}, bus_en} : wmark;
      end else begin : g_narrow
         assign rdata = (addr == REG_SEL_EN) ? bus_en : wmark;
      end
   endgenerate
endmodule

// File: rtl/dwm_burst_ctrl.sv
module dwm_burst_ctrl #(
   parameter int DEPTH     = 16,
   parameter int BURST_LEN = 4,
   localparam int CW       = $clog2(DEPTH + 1),
   localparam int BW       = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          bus_en,
   input  logic [CW-1:0] wmark,
   input  logic [CW-1:0] level,
   input  logic          empty,
   input  logic          gnt,
   input  logic          out_ready,
   output logic          req,
   output logic          out_valid,
   output logic          pop,
   output logic          in_burst,
   output logic [BW-1:0] beat
);
   import dwm_pkg::*;

   burst_st_e st_q;

   assign in_burst  = (st_q == ST_BURST);
   assign req       = (st_q == ST_IDLE) && bus_en && (level > wmark);
   assign out_valid = in_burst && !empty;
   assign pop       = out_valid && out_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q <= ST_IDLE;
         beat <= '0;
      end else begin
         case (st_q)
            ST_IDLE: if (req && gnt) begin
               st_q <= ST_BURST;
               beat <= '0;
            end
            ST_BURST: if (pop) begin
               if (beat == BW'(BURST_LEN - 1)) st_q <= ST_IDLE;
               else                            beat <= beat + BW'(1);
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/dma_wm_fifo.sv
module dma_wm_fifo #(
   parameter int DATA_W    = 32,
   parameter int DEPTH     = 16,
   parameter int BURST_LEN = 4,
   localparam int CW       = $clog2(DEPTH + 1),
   localparam int BW       = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic              reg_addr,
   input  logic [CW-1:0]     reg_wdata,
   output logic [CW-1:0]     reg_rdata,
   input  logic              push_valid,
   input  logic [DATA_W-1:0] push_data,
   output logic              full,
   output logic              burst_req,
   input  logic              burst_gnt,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_data,
   input  logic              out_ready
);
   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("DEPTH must be a power of two, at least 2");
      end
      if (BURST_LEN < 1 || BURST_LEN > DEPTH) begin : g_bad_burst
         $error("BURST_LEN must lie in 1..DEPTH");
      end
      if (DATA_W < 1) begin : g_bad_width
         $error("DATA_W must be positive");
      end
   endgenerate

   logic          bus_en;
   logic [CW-1:0] wmark;
   logic [CW-1:0] level;
   logic          empty;
   logic          pop;
   logic          in_burst;
   logic [BW-1:0] beat_cnt;

   dwm_regs #(.DEPTH(DEPTH)) u_regs (
      .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr),
      .wdata(reg_wdata), .rdata(reg_rdata), .bus_en(bus_en), .wmark(wmark)
   );

   dwm_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
      .clk(clk), .rst_n(rst_n), .wr_en(push_valid), .wr_data(push_data),
      .rd_en(pop), .rd_data(out_data), .level(level), .full(full), .empty(empty)
   );

   dwm_burst_ctrl #(.DEPTH(DEPTH), .BURST_LEN(BURST_LEN)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .wmark(wmark), .level(level),
      .empty(empty), .gnt(burst_gnt), .out_ready(out_ready), .req(burst_req),
      .out_valid(out_valid), .pop(pop), .in_burst(in_burst), .beat(beat_cnt)
   );
endmodule

// File: rtl/dwm_checker.sv
module dwm_checker #(
   parameter int DATA_W    = 32,
   parameter int DEPTH     = 16,
   parameter int BURST_LEN = 4,
   localparam int CW       = $clog2(DEPTH + 1),
   localparam int BW       = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_en,
   input logic [CW-1:0]     wmark,
   input logic [CW-1:0]     level,
   input logic              full,
   input logic              push_valid,
   input logic              burst_req,
   input logic              in_burst,
   input logic [BW-1:0]     beat_cnt,
   input logic              out_valid,
   input logic              out_ready,
   input logic [DATA_W-1:0] out_data
);
   assert_req_needs_enable_R3: assert property (@(posedge clk) disable iff (!rst_n)
      burst_req |-> bus_en);

   assert_req_above_wm_R4: assert property (@(posedge clk) disable iff (!rst_n)
      burst_req |-> (level > wmark));

   assert_valid_in_burst_R5: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> in_burst);

   assert_no_req_in_burst_R5: assert property (@(posedge clk) disable iff (!rst_n)
      in_burst |-> !burst_req);

   assert_beat_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
      beat_cnt <= BW'(BURST_LEN - 1));

   assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
      level <= CW'(DEPTH));

   assert_full_push_dropped_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (full && push_valid && !(out_valid && out_ready)) |=> (level == $past(level)));

   assert_hold_backpressure_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
endmodule

bind dma_wm_fifo dwm_checker #(.DATA_W(DATA_W), .DEPTH(DEPTH), .BURST_LEN(BURST_LEN)) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .wmark(wmark), .level(level),
   .full(full), .push_valid(push_valid), .burst_req(burst_req), .in_burst(in_burst),
   .beat_cnt(beat_cnt), .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
);

// File: tb/tb_dma_wm_fifo.sv
`timescale 1ns/1ps
module tb_dma_wm_fifo;
   localparam int DATA_W = 16;
   localparam int DEPTH  = 8;
   localparam int BL     = 4;
   localparam int CW     = $clog2(DEPTH + 1);

   logic              clk = 1'b0;
   logic              rst_n;
   logic              reg_we, reg_addr;
   logic [CW-1:0]     reg_wdata, reg_rdata;
   logic              push_valid;
   logic [DATA_W-1:0] push_data;
   logic              full, burst_req, burst_gnt, out_valid, out_ready;
   logic [DATA_W-1:0] out_data;

   int n_checks = 0;
   int n_fail   = 0;

   always #5 clk = ~clk;

   dma_wm_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH), .BURST_LEN(BL)) dut (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .push_valid(push_valid),
      .push_data(push_data), .full(full), .burst_req(burst_req),
      .burst_gnt(burst_gnt), .out_valid(out_valid), .out_data(out_data),
      .out_ready(out_ready)
   );

   // vector fields: watermark[9:6], pushes[5:2], expected req[1], expected full[0]
   localparam logic [9:0] VEC [7] = '{
      {4'd0, 4'd0, 1'b0, 1'b0},
      {4'd0, 4'd1, 1'b1, 1'b0},
      {4'd3, 4'd3, 1'b0, 1'b0},
      {4'd3, 4'd4, 1'b1, 1'b0},
      {4'd8, 4'd8, 1'b0, 1'b1},
      {4'd7, 4'd8, 1'b1, 1'b1},
      {4'd5, 4'd2, 1'b0, 1'b0}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic do_reset();
      rst_n = 1'b0; reg_we = 1'b0; reg_addr = 1'b0; reg_wdata = '0;
      push_valid = 1'b0; push_data = '0; burst_gnt = 1'b0; out_ready = 1'b0;
      step(); step();
      rst_n = 1'b1;
      step();
   endtask

   task automatic reg_write(input logic a, input logic [CW-1:0] d);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      step();
      reg_we = 1'b0;
   endtask

   task automatic push(input logic [DATA_W-1:0] d);
      push_valid = 1'b1; push_data = d;
      step();
      push_valid = 1'b0;
   endtask

   task automatic grant();
      burst_gnt = 1'b1;
      step();
      burst_gnt = 1'b0;
   endtask

   task automatic pop_check(input string req, input logic [DATA_W-1:0] exp);
      out_ready = 1'b1;
      chk(req, {31'd0, out_valid}, 32'd1);
      chk(req, {16'd0, out_data}, {16'd0, exp});
      step();
      out_ready = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      @(negedge clk);
      do_reset();
      // R1 reset state
      reg_addr = 1'b0; #1;
      chk("R1", {28'd0, reg_rdata}, 32'd0);
      reg_addr = 1'b1; #1;
      chk("R1", {28'd0, reg_rdata}, 32'd0);
      chk("R1", {29'd0, full, burst_req, out_valid}, 32'd0);

      // R2 register access
      reg_write(1'b1, 4'd5);
      reg_write(1'b0, 4'b1111);
      reg_addr = 1'b0; #1;
      chk("R2", {28'd0, reg_rdata}, 32'd1);
      reg_addr = 1'b1; #1;
      chk("R2", {28'd0, reg_rdata}, 32'd5);

      // R4 table walk: watermark against fill level
      for (int i = 0; i < 7; i++) begin
         do_reset();
         reg_write(1'b0, 4'd1);
         reg_write(1'b1, VEC[i][9:6]);
         for (int k = 0; k < int'(VEC[i][5:2]); k++) push(DATA_W'(k));
         chk("R4", {31'd0, burst_req}, {31'd0, VEC[i][1]});
         chk("R7", {31'd0, full}, {31'd0, VEC[i][0]});
      end

      // R3 enable gates requests
      do_reset();
      for (int k = 0; k < 5; k++) push(DATA_W'(k));
      chk("R3", {31'd0, burst_req}, 32'd0);
      reg_write(1'b0, 4'd1);
      chk("R3", {31'd0, burst_req}, 32'd1);

      // R5 burst drains past watermark, R8 backpressure
      do_reset();
      reg_write(1'b0, 4'd1);
      reg_write(1'b1, 4'd3);
      for (int k = 0; k < 3; k++) push(DATA_W'(16'hA0 + k));
      chk("R4", {31'd0, burst_req}, 32'd0);
      for (int k = 3; k < 5; k++) push(DATA_W'(16'hA0 + k));
      chk("R4", {31'd0, burst_req}, 32'd1);
      grant();
      chk("R5", {30'd0, burst_req, out_valid}, 32'd1);
      pop_check("R5", 16'hA0);
      step();
      chk("R8", {31'd0, out_valid}, 32'd1);
      chk("R8", {16'd0, out_data}, 32'hA1);
      for (int k = 1; k < 4; k++) pop_check("R5", DATA_W'(16'hA0 + k));
      chk("R5", {30'd0, burst_req, out_valid}, 32'd0);
      // empty in mid-burst
      reg_write(1'b1, 4'd0);
      chk("R4", {31'd0, burst_req}, 32'd1);
      grant();
      pop_check("R5", 16'hA4);
      chk("R5", {31'd0, out_valid}, 32'd0);
      push(16'hB0);
      pop_check("R5", 16'hB0);

      // R6 enable cleared mid-burst
      do_reset();
      reg_write(1'b0, 4'd1);
      for (int k = 0; k < 6; k++) push(DATA_W'(16'h60 + k));
      grant();
      pop_check("R6", 16'h60);
      reg_write(1'b0, 4'd0);
      for (int k = 1; k < 4; k++) pop_check("R6", DATA_W'(16'h60 + k));
      chk("R6", {30'd0, burst_req, out_valid}, 32'd0);
      reg_write(1'b0, 4'd1);
      chk("R6", {31'd0, burst_req}, 32'd1);

      // R7 push while full is dropped
      do_reset();
      for (int k = 0; k < 8; k++) push(DATA_W'(16'h70 + k));
      chk("R7", {31'd0, full}, 32'd1);
      push(16'hDEAD);
      chk("R7", {31'd0, full}, 32'd1);
      reg_write(1'b0, 4'd1);
      grant();
      for (int k = 0; k < 4; k++) pop_check("R7", DATA_W'(16'h70 + k));
      grant();
      for (int k = 4; k < 8; k++) pop_check("R7", DATA_W'(16'h70 + k));
      chk("R7", {30'd0, burst_req, out_valid}, 32'd0);

      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule